// File: doc/BRIEF.md
# Eight-bit Flag-Producing ALU

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. Two operands, a carry input and a 3-bit operation code go in. An 8-bit result and four status flags come out in the same cycle: zero, negative, carry and overflow. The block holds no state, so a surrounding pipeline or register file registers the outputs wherever it needs to.

The unit supports three bitwise operations, add with carry, and subtract with an inverted borrow. It also supports rotate through carry and logical shift. For rotate and shift, operand B does not carry data. It holds a direction code instead. The outputs are plain combinational signals with no valid/ready handshake: a new operand set is accepted on every cycle and cannot be held off, so back-pressure belongs to the logic that captures the result. The operand width is a parameter whose default is eight.

Top module: `alu8_core`

## Requirements
- R1: Op codes 0, 1 and 2 give A OR B, A AND B and A XOR B. On these codes the carry flag equals the carry input.
- R2: Op code 3 (add) gives {carry flag, result} = A + B + C, treating all values as unsigned.
- R3: Op codes 3 and 4 set the overflow flag when the signed result of the operation does not fit in 8 bits.
- R4: Op code 4 (subtract) gives result = A − B − (1 − C) modulo 256. Its carry flag is 1 when no borrow occurs (A ≥ B + (1 − C)) and 0 otherwise.
- R5: Op code 5 (rotate) with B = 0x00 (left) gives result {A[6:0], C} and carry flag A[7].
- R6: Op code 5 with B = 0x01 (right) gives result {C, A[7:1]} and carry flag A[0].
- R7: Op code 6 (shift) moves a zero into the vacated bit: left gives {A[6:0], 0}, right (B = 0x01) gives {0, A[7:1]}. The carry flag holds the bit shifted out.
- R8: For op codes 5 and 6, any B value other than 0x01 selects the left direction.
- R9: For every op code, the zero flag is 1 exactly when the result is 0x00, and the negative flag equals result bit 7.
- R10: Op code 7 is reserved. It gives result 0x00, carry flag equal to the carry input, and overflow 0.
- R11: The overflow flag is 0 for every op code other than 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, or direction code for rotate and shift |
| cin_i | input | 1 | Carry input (inverted borrow on subtract) |
| op_i | input | 3 | Operation code |
| y_o | output | 8 | Result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
Carry-out and signed overflow can both be raised by the same operation, and the zero flag can rise with them. Adding 0x80 to 0x80 produces all three at once. Subtracting 0x01 from 0x80 with the borrow active raises overflow while carry stays at 1. The bench drives these operand pairs and compares each flag on its own against values computed from the requirement arithmetic. A sweep of operand pairs over every op code confirms that each flag takes its correct value in every combination.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    ALU_OR  = 3'd0,
    ALU_AND = 3'd1,
    ALU_XOR = 3'd2,
    ALU_ADD = 3'd3,
    ALU_SUB = 3'd4,
    ALU_ROT = 3'd5,
    ALU_SHF = 3'd6,
    ALU_RSV = 3'd7
  } alu_op_e;

  localparam int unsigned DIR_RIGHT_CODE = 1;
endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i | b_i;
      2'd1:    res_o = a_i & b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  // Subtraction reuses the adder: A + ~B + C equals A - B - (1 - C).
  logic [W-1:0] bb;
  logic [W:0]   cy;

  assign bb    = sub_i ? ~b_i : b_i;
  assign cy[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ bb[i] ^ cy[i];
    assign cy[i+1]  = (a_i[i] & bb[i]) | (cy[i] & (a_i[i] ^ bb[i]));
  end

  assign cout_o = cy[W];
  assign ovf_o  = cy[W] ^ cy[W-1];
endmodule

// File: rtl/alu8_shift_unit.sv
module alu8_shift_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         rotate_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  import alu8_pkg::*;

  logic go_right;
  logic fill;

  assign go_right = (b_i == W'(DIR_RIGHT_CODE));
  assign fill     = rotate_i & cin_i;

  always_comb begin
    if (go_right) begin
      res_o  = {fill, a_i[W-1:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[W-2:0], fill};
      cout_o = a_i[W-1];
    end
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit #(
  parameter int unsigned W = 8
) (
  input  alu8_pkg::alu_op_e op_i,
  input  logic [W-1:0]      logic_res_i,
  input  logic [W-1:0]      arith_res_i,
  input  logic              arith_c_i,
  input  logic              arith_v_i,
  input  logic [W-1:0]      shift_res_i,
  input  logic              shift_c_i,
  input  logic              cin_i,
  output logic [W-1:0]      y_o,
  output logic              z_o,
  output logic              n_o,
  output logic              c_o,
  output logic              v_o
);
  import alu8_pkg::*;

  always_comb begin
    y_o = '0;
    c_o = cin_i;
    v_o = 1'b0;
    unique case (op_i)
      ALU_OR, ALU_AND, ALU_XOR: y_o = logic_res_i;
      ALU_ADD, ALU_SUB: begin
        y_o = arith_res_i;
        c_o = arith_c_i;
        v_o = arith_v_i;
      end
      ALU_ROT, ALU_SHF: begin
        y_o = shift_res_i;
        c_o = shift_c_i;
      end
      default: ;
    endcase
  end

  assign z_o = ~|y_o;
  assign n_o = y_o[W-1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         z_o,
  output logic         n_o,
  output logic         c_o,
  output logic         v_o
);
  import alu8_pkg::*;

  alu_op_e      op;
  logic [W-1:0] logic_res, arith_res, shift_res;
  logic         arith_c, arith_v, shift_c;

  assign op = alu_op_e'(op_i);

  alu8_logic_unit #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(op_i[1:0]), .res_o(logic_res)
  );

  alu8_arith_unit #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sub_i(op == ALU_SUB),
    .sum_o(arith_res), .cout_o(arith_c), .ovf_o(arith_v)
  );

  alu8_shift_unit #(.W(W)) u_shift (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .rotate_i(op == ALU_ROT),
    .res_o(shift_res), .cout_o(shift_c)
  );

  alu8_flag_unit #(.W(W)) u_flags (
    .op_i(op), .logic_res_i(logic_res), .arith_res_i(arith_res),
    .arith_c_i(arith_c), .arith_v_i(arith_v), .shift_res_i(shift_res),
    .shift_c_i(shift_c), .cin_i(cin_i), .y_o(y_o), .z_o(z_o), .n_o(n_o),
    .c_o(c_o), .v_o(v_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] y_o,
  input logic         z_o,
  input logic         n_o,
  input logic         c_o,
  input logic         v_o
);
  logic [W:0] add_ref;
  logic [W:0] sub_ref;

  assign add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sub_ref = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, ~cin_i};

  always_comb begin
    if (op_i == 3'd3) begin
      a_r2_add_sum: assert ({c_o, y_o} == add_ref);
    end
    if (op_i == 3'd4) begin
      a_r4_sub_diff: assert (y_o == sub_ref[W-1:0] && c_o == ~sub_ref[W]);
    end
    if (op_i != 3'd3 && op_i != 3'd4) begin
      a_r11_no_overflow: assert (!v_o);
    end
    if (op_i == 3'd5 && b_i == '0) begin
      a_r5_rot_left: assert (c_o == a_i[W-1] && y_o[0] == cin_i);
    end
    if (op_i == 3'd6) begin
      a_r7_shift_fill: assert (b_i == W'(1) ? !y_o[W-1] : !y_o[0]);
    end
    if (op_i == 3'd7) begin
      a_r10_reserved: assert (y_o == '0 && c_o == cin_i && z_o);
    end
    a_r9_neg_flag: assert (n_o == y_o[W-1]);
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i), .y_o(y_o),
  .z_o(z_o), .n_o(n_o), .c_o(c_o), .v_o(v_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] a, b, y;
  logic       cin;
  logic [2:0] op;
  logic       z, n, c, v;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core uut (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(op),
    .y_o(y), .z_o(z), .n_o(n), .c_o(c), .v_o(v)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [7:0] x, input logic [7:0] w, input logic ci);
    @(negedge clk);
    op = o; a = x; b = w; cin = ci;
    #1;
  endtask

  // Independent model built from the requirement text.
  task automatic expect_all(input string req);
    logic [8:0] full;
    logic [7:0] ey;
    logic       ec, ev;
    int         sa, sb, sr;
    ec = cin; ev = 1'b0; ey = 8'h00;
    sa = $signed(a); sb = $signed(b);
    case (op)
      3'd0: ey = a | b;
      3'd1: ey = a & b;
      3'd2: ey = a ^ b;
      3'd3: begin
        full = 9'(a) + 9'(b) + 9'(cin); ey = full[7:0]; ec = full[8];
        sr = sa + sb + int'(cin); ev = (sr > 127 || sr < -128);
      end
      3'd4: begin
        ey = 8'(int'(a) - int'(b) - (1 - int'(cin)));
        ec = (int'(a) >= int'(b) + (1 - int'(cin)));
        sr = sa - sb - (1 - int'(cin)); ev = (sr > 127 || sr < -128);
      end
      3'd5, 3'd6: begin
        if (b == 8'h01) begin ey = {(op == 3'd5) ? cin : 1'b0, a[7:1]}; ec = a[0]; end
        else            begin ey = {a[6:0], (op == 3'd5) ? cin : 1'b0}; ec = a[7]; end
      end
      default: ;
    endcase
    chk(req, "result", y, ey);
    chk(req, "carry", c, ec);
    chk(req, "overflow", v, ev);
    chk("R9", "zero", z, ey == 8'h00);
    chk("R9", "negative", n, ey[7]);
  endtask

  task automatic t_idle_state;
    drive(3'd0, 8'h00, 8'h00, 1'b0);
    chk("R9", "idle zero", z, 1); chk("R1", "idle result", y, 0);
  endtask

  task automatic t_logic;
    drive(3'd0, 8'h11, 8'h22, 1'b0); chk("R1", "or", y, 8'h33);
    drive(3'd1, 8'h11, 8'h22, 1'b1); chk("R1", "and", y, 8'h00); chk("R1", "carry pass", c, 1);
    drive(3'd2, 8'h11, 8'h22, 1'b0); chk("R1", "xor", y, 8'h33);
    drive(3'd2, 8'h22, 8'h22, 1'b0); chk("R1", "xor equal", y, 8'h00); chk("R9", "zero", z, 1);
  endtask

  task automatic t_add;
    drive(3'd3, 8'h22, 8'h22, 1'b0); chk("R2", "add", y, 8'h44);
    drive(3'd3, 8'h22, 8'h22, 1'b1); chk("R2", "add carry in", y, 8'h45);
    drive(3'd3, 8'hF0, 8'h10, 1'b0); chk("R2", "carry out", c, 1); chk("R2", "wrap", y, 0);
  endtask

  task automatic t_sub;
    drive(3'd4, 8'hF0, 8'h10, 1'b0); chk("R4", "sub borrow", y, 8'hDF); chk("R4", "no borrow out", c, 1);
    drive(3'd4, 8'hF0, 8'h10, 1'b1); chk("R4", "sub", y, 8'hE0);
    drive(3'd4, 8'h10, 8'h20, 1'b1); chk("R4", "borrow out", c, 0);
  endtask

  task automatic t_flags_together;
    drive(3'd3, 8'h80, 8'h80, 1'b0);
    chk("R3", "ovf", v, 1); chk("R2", "carry", c, 1); chk("R9", "zero", z, 1);
    drive(3'd4, 8'h80, 8'h01, 1'b1);
    chk("R3", "sub ovf", v, 1); chk("R4", "sub carry", c, 1); chk("R9", "neg", n, 0);
    drive(3'd3, 8'h7F, 8'h00, 1'b1); chk("R3", "pos ovf", v, 1); chk("R9", "neg", n, 1);
  endtask

  task automatic t_rotate;
    drive(3'd5, 8'hF0, 8'h00, 1'b1); chk("R5", "rol", y, 8'hE1); chk("R5", "rol c", c, 1);
    drive(3'd5, 8'hF0, 8'h00, 1'b0); chk("R5", "rol c0", y, 8'hE0);
    drive(3'd5, 8'hF0, 8'h01, 1'b0); chk("R6", "ror", y, 8'h78); chk("R6", "ror c", c, 0);
    drive(3'd5, 8'hF1, 8'h01, 1'b1); chk("R6", "ror c1", y, 8'hF8); chk("R6", "ror cout", c, 1);
  endtask

  task automatic t_shift;
    drive(3'd6, 8'hF9, 8'h00, 1'b1); chk("R7", "shl", y, 8'hF2); chk("R7", "shl c", c, 1);
    drive(3'd6, 8'hF9, 8'h01, 1'b0); chk("R7", "shr", y, 8'h7C); chk("R7", "shr c", c, 1);
    drive(3'd6, 8'h81, 8'h02, 1'b0); chk("R8", "other code left", y, 8'h02);
    drive(3'd5, 8'h81, 8'hFF, 1'b0); chk("R8", "rot other code", y, 8'h02); chk("R8", "c", c, 1);
  endtask

  task automatic t_reserved;
    drive(3'd7, 8'hAA, 8'h55, 1'b1);
    chk("R10", "result", y, 0); chk("R10", "carry", c, 1); chk("R11", "ovf", v, 0);
  endtask

  task automatic t_sweep;
    logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hA5, 8'hFF};
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 2; k++) begin
            drive(3'(o), vals[i], vals[j], k[0]);
            expect_all(o < 3 ? "R1" : o == 3 ? "R2" : o == 4 ? "R4" :
                       o == 5 ? "R5" : o == 6 ? "R7" : "R10");
          end
  endtask

  initial begin
    a = 0; b = 0; cin = 0; op = 0;
    t_idle_state();
    t_logic();
    t_add();
    t_sub();
    t_flags_together();
    t_rotate();
    t_shift();
    t_reserved();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule